// File: doc/BRIEF.md
# N+1 Spare Input Steering Router

This block sits in front of a bank of serial-to-parallel channels. It has one serial input per channel and one extra spare input. A registered select code picks which channel, if any, takes the spare stream in place of its own. The primary stream that is pushed out is sent, undecoded, to a single monitor output, so the link being replaced can still be watched at low speed. Two codes above the channel range are reserved. One parks the spare and turns the monitor off. The other leaves every channel on its own input and copies the spare to the monitor.

The block also gates what the channels send back toward the board: per-channel parallel words, recovered clocks and lock flags. A power-on control and an output-enable control do this gating. Every gated output comes as a value plus an enable flag, so a high-impedance pin is modelled as enable low with the value held at zero. The monitor has its own enable input, and that enable passes through a short register pipeline before it acts.

Top module: `spare_route_top`

## Requirements
- R1: With registered select code n in 0..NCH-1, the serial input to channel n (`des_in[n]`) equals `spare_in`, and when the monitor is enabled `mon_out` equals `prim_in[n]`.
- R2: Every channel whose index differs from the registered select code receives its own `prim_in[i]` on `des_in[i]`.
- R3: With registered code NCH (6 by default, "park"), the spare is used by no channel and `mon_oe` is 0 with `mon_out` 0.
- R4: With registered code NCH+1 (7 by default, "pass"), every channel receives its own primary input and, when the monitor is enabled, `mon_out` equals `spare_in`.
- R5: With `pwr_on` low, every enable flag (`word_oe`, `rclk_oe`, `lock_oe`, `mon_oe`) is 0 and every gated value is 0, whatever the select code.
- R6: With `pwr_on` high and `out_en` low, `word_oe`, `rclk_oe` and `mon_oe` are 0 while `lock_oe` is all ones and `lock_out` follows `lock_in`.
- R7: `mon_oe` is 1 exactly when `pwr_on` and `out_en` are high, the registered code is not park, and `mon_en` was high at the clock edge two edges back. A change on `mon_en` therefore acts two cycles later.
- R8: `sel_code` is sampled on each rising clock edge, so a new code changes routing only after the next edge. Reset loads all ones (code 7, pass), so during and right after reset every channel carries its own primary input.
- R9: With `pwr_on` and `out_en` high, `word_out`, `rclk_out` and `lock_out` equal `word_in`, `rclk_in` and `lock_in`, and all their enable flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the select and monitor-enable registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | High runs the block; low forces every output off |
| out_en | input | 1 | High enables word, clock and monitor outputs |
| mon_en | input | 1 | Monitor enable request, acts two cycles later |
| sel_code | input | 3 | Spare steering code: 0..5 substitute, 6 park, 7 pass |
| prim_in | input | 6 | Primary serial inputs, one per channel |
| spare_in | input | 1 | Spare serial input |
| word_in | input | 60 | Parallel words from the channels, 10 bits each |
| rclk_in | input | 6 | Recovered clocks from the channels |
| lock_in | input | 6 | Lock flags from the channels |
| des_in | output | 6 | Serial stream steered into each channel |
| word_out | output | 60 | Gated parallel words |
| word_oe | output | 6 | Per-channel word drive enable |
| rclk_out | output | 6 | Gated recovered clocks |
| rclk_oe | output | 6 | Per-channel clock drive enable |
| lock_out | output | 6 | Gated lock flags |
| lock_oe | output | 6 | Per-channel lock drive enable |
| mon_out | output | 1 | Undecoded monitor stream |
| mon_oe | output | 1 | Monitor drive enable |

## Verification
Three things can land on the same clock edge: a select-code change, which moves the spare and the monitor source, and a flip of the delayed monitor enable or a power or output-enable transition, which changes whether the monitor drives at all. The random phase changes `sel_code`, `mon_en`, `pwr_on` and `out_en` independently every cycle, so these meet often. Directed steps also put a park code and a rising monitor enable together. Each cycle the monitor value and its enable are compared against a bench model that keeps its own copies of the registered code and the two-stage enable. Outputs are sampled both before and after each new drive, so a code that acted before its edge shows up as an error.

// File: rtl/spare_route_pkg.sv
package spare_route_pkg;

    // Drive permissions derived from the two global controls.
    typedef struct packed {
        logic data_en;   // words and recovered clocks
        logic lock_en;   // lock flags
        logic mon_en;    // monitor, before its own delayed enable
    } gate_ctl_t;

    function automatic gate_ctl_t gate_decode(input logic pwr_on, input logic out_en);
        gate_ctl_t g;
        g.lock_en = pwr_on;
        g.data_en = pwr_on & out_en;
        g.mon_en  = pwr_on & out_en;
        return g;
    endfunction

endpackage

// File: rtl/spare_route_ctrl.sv
module spare_route_ctrl #(
    parameter int NCH     = 6,
    parameter int MON_LAT = 2,
    localparam int SEL_W  = $clog2(NCH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_code,
    input  logic             mon_en,
    output logic [SEL_W-1:0] sel_q,
    output logic             mon_en_eff
);

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [MON_LAT-1:0] pipe;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sel  = sel_code;
        st_d.pipe = (st_q.pipe << 1) | MON_LAT'(mon_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel  <= '1;   // undriven select reads as all ones
            st_q.pipe <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q      = st_q.sel;
    assign mon_en_eff = st_q.pipe[MON_LAT-1];

    generate
        if (MON_LAT >= 2) begin : g_lat_chk
            AST_MON_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mon_en) |=> !mon_en_eff)
                else $error("monitor enable acted too early"); // R7
        end
    endgenerate

endmodule

// File: rtl/spare_route_xbar.sv
module spare_route_xbar #(
    parameter int NCH    = 6,
    localparam int SEL_W = $clog2(NCH + 2)
) (
    input  logic [SEL_W-1:0] sel_q,
    input  logic [NCH-1:0]   prim_in,
    input  logic             spare_in,
    output logic [NCH-1:0]   des_in,
    output logic             mon_bit,
    output logic             mon_park
);

    localparam logic [SEL_W-1:0] CODE_PARK = SEL_W'(NCH);

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_ch
            assign des_in[gi] = (sel_q == SEL_W'(gi)) ? spare_in : prim_in[gi];
        end
    endgenerate

    // Displaced primary goes to the monitor; codes above park pass the spare.
    always_comb begin
        mon_bit = spare_in;
        for (int i = 0; i < NCH; i++) begin
            if (sel_q == SEL_W'(i)) mon_bit = prim_in[i];
        end
    end

    assign mon_park = (sel_q == CODE_PARK);

endmodule

// File: rtl/spare_route_gate.sv
module spare_route_gate
    import spare_route_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int WORD_W = 10,
    localparam int BUS_W = NCH * WORD_W
) (
    input  logic             pwr_on,
    input  logic             out_en,
    input  logic             mon_en_eff,
    input  logic             mon_park,
    input  logic             mon_bit,
    input  logic [BUS_W-1:0] word_in,
    input  logic [NCH-1:0]   rclk_in,
    input  logic [NCH-1:0]   lock_in,
    output logic [BUS_W-1:0] word_out,
    output logic [NCH-1:0]   word_oe,
    output logic [NCH-1:0]   rclk_out,
    output logic [NCH-1:0]   rclk_oe,
    output logic [NCH-1:0]   lock_out,
    output logic [NCH-1:0]   lock_oe,
    output logic             mon_out,
    output logic             mon_oe
);

    gate_ctl_t g;
    assign g = gate_decode(pwr_on, out_en);

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_ch
            assign word_out[gi*WORD_W +: WORD_W] = word_in[gi*WORD_W +: WORD_W] & {WORD_W{g.data_en}};
            assign word_oe[gi]  = g.data_en;
            assign rclk_out[gi] = rclk_in[gi] & g.data_en;
            assign rclk_oe[gi]  = g.data_en;
            assign lock_out[gi] = lock_in[gi] & g.lock_en;
            assign lock_oe[gi]  = g.lock_en;
        end
    endgenerate

    assign mon_oe  = g.mon_en & mon_en_eff & ~mon_park;
    assign mon_out = mon_bit & mon_oe;

endmodule

// File: rtl/spare_route_top.sv
module spare_route_top #(
    parameter int NCH     = 6,
    parameter int WORD_W  = 10,
    parameter int MON_LAT = 2,
    localparam int SEL_W  = $clog2(NCH + 2),
    localparam int BUS_W  = NCH * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             out_en,
    input  logic             mon_en,
    input  logic [SEL_W-1:0] sel_code,
    input  logic [NCH-1:0]   prim_in,
    input  logic             spare_in,
    input  logic [BUS_W-1:0] word_in,
    input  logic [NCH-1:0]   rclk_in,
    input  logic [NCH-1:0]   lock_in,
    output logic [NCH-1:0]   des_in,
    output logic [BUS_W-1:0] word_out,
    output logic [NCH-1:0]   word_oe,
    output logic [NCH-1:0]   rclk_out,
    output logic [NCH-1:0]   rclk_oe,
    output logic [NCH-1:0]   lock_out,
    output logic [NCH-1:0]   lock_oe,
    output logic             mon_out,
    output logic             mon_oe
);

    logic [SEL_W-1:0] sel_q;
    logic             mon_en_eff;
    logic             mon_bit;
    logic             mon_park;

    spare_route_ctrl #(.NCH(NCH), .MON_LAT(MON_LAT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_code   (sel_code),
        .mon_en     (mon_en),
        .sel_q      (sel_q),
        .mon_en_eff (mon_en_eff)
    );

    spare_route_xbar #(.NCH(NCH)) u_xbar (
        .sel_q    (sel_q),
        .prim_in  (prim_in),
        .spare_in (spare_in),
        .des_in   (des_in),
        .mon_bit  (mon_bit),
        .mon_park (mon_park)
    );

    spare_route_gate #(.NCH(NCH), .WORD_W(WORD_W)) u_gate (
        .pwr_on     (pwr_on),
        .out_en     (out_en),
        .mon_en_eff (mon_en_eff),
        .mon_park   (mon_park),
        .mon_bit    (mon_bit),
        .word_in    (word_in),
        .rclk_in    (rclk_in),
        .lock_in    (lock_in),
        .word_out   (word_out),
        .word_oe    (word_oe),
        .rclk_out   (rclk_out),
        .rclk_oe    (rclk_oe),
        .lock_out   (lock_out),
        .lock_oe    (lock_oe),
        .mon_out    (mon_out),
        .mon_oe     (mon_oe)
    );

    AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> (lock_oe == '0 && word_oe == '0 && rclk_oe == '0 && !mon_oe && word_out == '0))
        else $error("outputs driven while powered down"); // R5

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && !out_en) |-> (lock_oe == '1 && lock_out == lock_in && word_oe == '0 && !mon_oe))
        else $error("lock or data gating wrong with outputs disabled"); // R6

    AST_PARK_MON: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == SEL_W'(NCH)) |=> !mon_oe)
        else $error("monitor driven under park code"); // R3

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_chk
            AST_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_code == SEL_W'(gi)) |=> (des_in[gi] == spare_in))
                else $error("spare not steered into selected channel"); // R1
            AST_MON_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_code == SEL_W'(gi)) |=> (!mon_oe || mon_out == prim_in[gi]))
                else $error("displaced primary not on monitor"); // R1
        end
    endgenerate

endmodule

// File: tb/spare_route_top_bench.sv
`timescale 1ns/1ps
module spare_route_top_bench;

    localparam int NCH    = 6;
    localparam int WORD_W = 10;
    localparam int SEL_W  = 3;
    localparam int BUS_W  = NCH * WORD_W;
    localparam int PARK   = NCH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_on = 1'b0, out_en = 1'b0, mon_en = 1'b0, spare_in = 1'b0;
    logic [SEL_W-1:0] sel_code = '0;
    logic [NCH-1:0]   prim_in = '0, rclk_in = '0, lock_in = '0;
    logic [BUS_W-1:0] word_in = '0;
    logic [NCH-1:0]   des_in, word_oe, rclk_out, rclk_oe, lock_out, lock_oe;
    logic [BUS_W-1:0] word_out;
    logic             mon_out, mon_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spare_route_top u_spare_route_top (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .out_en(out_en), .mon_en(mon_en),
        .sel_code(sel_code), .prim_in(prim_in), .spare_in(spare_in), .word_in(word_in),
        .rclk_in(rclk_in), .lock_in(lock_in), .des_in(des_in), .word_out(word_out),
        .word_oe(word_oe), .rclk_out(rclk_out), .rclk_oe(rclk_oe), .lock_out(lock_out),
        .lock_oe(lock_oe), .mon_out(mon_out), .mon_oe(mon_oe)
    );

    // Bench-side model of the registered state.
    logic [SEL_W-1:0] m_sel;
    logic [1:0]       m_en;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sel <= 3'd7;
            m_en  <= 2'b00;
        end else begin
            m_sel <= sel_code;
            m_en  <= {m_en[0], mon_en};
        end
    end

    function automatic logic exp_des(input int i);
        return (int'(m_sel) == i) ? spare_in : prim_in[i];
    endfunction

    function automatic logic exp_mon_oe();
        return pwr_on & out_en & m_en[1] & (int'(m_sel) != PARK);
    endfunction

    function automatic logic exp_mon_out();
        logic b;
        b = (int'(m_sel) < NCH) ? prim_in[m_sel] : spare_in;
        return b & exp_mon_oe();
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        string pre, mtag, gtag;
        logic  den, len;
        pre = (sel_code != m_sel) ? "R8 " : "";
        for (int i = 0; i < NCH; i++) begin
            if (int'(m_sel) == i)      chk({pre, "R1 des_in"}, 64'(des_in[i]), 64'(exp_des(i)));
            else if (int'(m_sel) == PARK) chk({pre, "R3 des_in"}, 64'(des_in[i]), 64'(exp_des(i)));
            else if (int'(m_sel) > PARK)  chk({pre, "R4 des_in"}, 64'(des_in[i]), 64'(exp_des(i)));
            else                       chk({pre, "R2 des_in"}, 64'(des_in[i]), 64'(exp_des(i)));
        end
        if (!pwr_on)               mtag = "R5 mon";
        else if (!out_en)          mtag = "R6 mon";
        else if (int'(m_sel) == PARK) mtag = "R3 mon";
        else if (int'(m_sel) > PARK)  mtag = "R4/R7 mon";
        else                       mtag = "R1/R7 mon";
        chk({mtag, "_oe"}, 64'(mon_oe), 64'(exp_mon_oe()));
        chk({mtag, "_out"}, 64'(mon_out), 64'(exp_mon_out()));
        den = pwr_on & out_en;
        len = pwr_on;
        gtag = !pwr_on ? "R5" : (!out_en ? "R6" : "R9");
        chk({gtag, " word_oe"}, 64'(word_oe), 64'({NCH{den}}));
        chk({gtag, " rclk"}, 64'({rclk_oe, rclk_out}), 64'({{NCH{den}}, rclk_in & {NCH{den}}}));
        chk({gtag, " lock"}, 64'({lock_oe, lock_out}), 64'({{NCH{len}}, lock_in & {NCH{len}}}));
        chk({gtag, " word_out"}, 64'(word_out), 64'(word_in & {BUS_W{den}}));
    endtask

    task automatic rand_data();
        prim_in  = NCH'($urandom);
        spare_in = 1'($urandom);
        rclk_in  = NCH'($urandom);
        lock_in  = NCH'($urandom);
        word_in  = {$urandom, $urandom};
    endtask

    // One cycle: check settled state, drive new inputs, recheck before the edge.
    task automatic cycle(input logic [SEL_W-1:0] s, input logic p, input logic o, input logic m);
        @(negedge clk);
        check_all();
        sel_code = s; pwr_on = p; out_en = o; mon_en = m;
        rand_data();
        #1;
        check_all();
    endtask

    initial begin
        void'($urandom(32'h5A17_0C3D));
        // Reset default: code 7 -> each channel on its own input (R8).
        pwr_on = 1; out_en = 1; mon_en = 1; sel_code = 3'd0;
        prim_in = '0; spare_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 reset des_in", 64'(des_in), 64'(0));
        chk("R7 reset mon_oe", 64'(mon_oe), 64'(0));
        check_all();
        rst_n = 1;

        // Monitor enable latency (R7): held high since reset, acts after two edges.
        cycle(3'd7, 1, 1, 1);
        cycle(3'd7, 1, 1, 1);
        cycle(3'd7, 1, 1, 0);
        cycle(3'd7, 1, 1, 0);
        cycle(3'd7, 1, 1, 1);
        cycle(3'd7, 1, 1, 1);
        // Every code, directed (R1 R2 R3 R4 R8).
        for (int c = 0; c < 8; c++) begin
            cycle(3'(c), 1, 1, 1);
            cycle(3'(c), 1, 1, 1);
        end
        // Park code meeting a rising monitor enable (R3 R7).
        cycle(3'd6, 1, 1, 0);
        cycle(3'd6, 1, 1, 1);
        cycle(3'd2, 1, 1, 1);
        cycle(3'd2, 1, 1, 1);
        // Power-down and output-disable (R5 R6).
        cycle(3'd1, 0, 1, 1);
        cycle(3'd1, 0, 1, 1);
        cycle(3'd1, 1, 0, 1);
        cycle(3'd1, 1, 0, 1);
        cycle(3'd1, 1, 1, 1);
        // Random phase.
        for (int k = 0; k < 4000; k++) begin
            logic [SEL_W-1:0] s;
            logic p, o, m;
            s = ($urandom_range(3, 0) == 0) ? 3'($urandom) : sel_code;
            p = ($urandom_range(9, 0) != 0);
            o = ($urandom_range(6, 0) != 0);
            m = ($urandom_range(4, 0) == 0) ? ~mon_en : mon_en;
            cycle(s, p, o, m);
        end
        @(negedge clk);
        check_all();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule